// File: doc/BRIEF.md
# Idle-Locked Descrambler with Code-Group Alignment

This block sits on the receive side of a 100 Mb/s twisted-pair link, after clock and data recovery. It takes one recovered line bit per valid strobe and removes the stream-cipher scrambling. The key stream comes from an 11-bit linear feedback register with feedback s[n] = s[n-11] XOR s[n-9]. To acquire the key stream, the block assumes the line is idle, which is all ones before scrambling. It loads its register from the inverted received bits, then confirms the guess over a run of correctly predicted bits.

Once locked, a supervisor checks each window of received bits for a run of at least 25 consecutive descrambled ones. If a window closes without such a run, the block drops lock and starts acquisition again. The descrambled bits are grouped into 5-bit code groups, aligned on the start-of-stream delimiter pair 11000 then 10001. Alignment is held until lock is lost.

Two pass-through selections skip the descrambler: an explicit bypass, and 10 Mb/s operation. In either case the raw bits are grouped directly on the same delimiter.

Top module: `idle_sync_descrambler`

## Requirements
- R1: After reset, `locked` and `aligned` are 0, `grp_vld` is 0 and `grp_data` is 11111.
- R2: Starting from the hunt state, the first 11 valid bits seed the key register; `locked` rises on the clock edge that takes the 30th consecutive bit after that which descrambles to one. On a clean idle line this is the 41st valid bit.
- R3: While locked, every descrambled bit equals the received bit XOR s[n], with s[n] = s[n-11] XOR s[n-9], so the code groups carry the transmitted plaintext.
- R4: The supervision window is WIN_LEN valid bits, starting with the first bit after lock. Lock is kept if a run of 25 or more consecutive descrambled ones reaches its 25th bit (or continues) inside the window.
- R5: If a window's last bit passes without such a run, `locked` falls on that bit's edge, and reacquisition starts from scratch, again needing 11 + 30 bits.
- R6: Alignment is set when the last ten descrambled bits are 11000 10001, with the earliest bit in the leftmost position. On that edge the J group 11000 is presented with a one-cycle `grp_vld`. Each later group is presented when the five bits that follow it have arrived. `grp_data[4]` is the earliest bit of a group.
- R7: While `aligned` is 0, `grp_vld` stays 0 and `grp_data` is 11111.
- R8: In descramble mode, alignment is found only while locked and is cleared on the edge where lock falls. A group that would be presented on that edge is dropped.
- R9: With `bypass` high, bits are not descrambled, `locked` is held at 0, and raw groups are aligned and presented as in R6.
- R10: With `mode_10m` high, behaviour is the same as in R9.
- R11: Any change of the pass-through selection (`bypass` OR `mode_10m`) clears `aligned` on the next edge.
- R12: Cycles with `rx_vld` low change no bit count, window count or group phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered line bit |
| rx_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| bypass | input | 1 | Skip descrambling, pass raw bits to grouping |
| mode_10m | input | 1 | 10 Mb/s operation, no descrambling |
| grp_data | output | GRP_W | Aligned code group, 11111 when unaligned |
| grp_vld | output | 1 | One-cycle strobe for a new code group |
| locked | output | 1 | Descrambler key stream is synchronized |
| aligned | output | 1 | Group boundary found from the delimiter |

## Verification
The hardest case to reach is losing lock on the exact bit that closes a supervision window. This needs the bench to know where every window starts. The bench counts valid bits from the edge on which `locked` rises and compares 25-one and 24-one runs placed inside known windows. It sends an aligned stream of zero groups for a whole window, which pins down the bit where lock falls and the last group that may still be presented. Bypass and 10 Mb/s groups are then checked with the same scoreboard, using unscrambled bits.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic {
      SYNC_HUNT = 1'b0,
      SYNC_LOCK = 1'b1
   } sync_state_t;

   // start-of-stream pair, earliest bit in the MSB
   localparam logic [9:0] SSD_PAIR  = 10'b11000_10001;
   localparam logic [4:0] IDLE_CODE = 5'b11111;

endpackage

// File: rtl/dsc_keystream.sv
module dsc_keystream #(
   parameter int LEN = 11,
   parameter int TAP = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic load_raw,
   input  logic rx_bit,
   output logic ks_bit,
   output logic hist_nz
);

   // hist[0] holds s[n-1], hist[k] holds s[n-1-k]
   logic [LEN-1:0] hist;

   assign ks_bit  = hist[LEN-1] ^ hist[TAP-1];
   assign hist_nz = |hist;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0;
      end else if (shift_en) begin
         hist <= {hist[LEN-2:0], (load_raw ? ~rx_bit : ks_bit)};
      end
   end

endmodule

// File: rtl/dsc_sync_mon.sv
module dsc_sync_mon #(
   parameter int LEN      = 11,
   parameter int ACQ_RUN  = 30,
   parameter int IDLE_RUN = 25,
   parameter int WIN_LEN  = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic bit_vld,
   input  logic desc_bit,
   input  logic hist_nz,
   output logic locked,
   output logic lock_nxt,
   output logic hunting
);
   import dsc_pkg::*;

   localparam int FILL_W = $clog2(LEN + 1);
   localparam int ACQ_W  = $clog2(ACQ_RUN + 1);
   localparam int RUN_W  = $clog2(IDLE_RUN + 1);
   localparam int WIN_W  = $clog2(WIN_LEN + 1);
   localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(LEN);
   localparam logic [ACQ_W-1:0]  ACQ_LAST = ACQ_W'(ACQ_RUN - 1);
   localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(IDLE_RUN);
   localparam logic [RUN_W-1:0]  RUN_HIT  = RUN_W'(IDLE_RUN - 1);
   localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_LEN - 1);

   sync_state_t       st, st_n;
   logic [FILL_W-1:0] fill, fill_n;
   logic [ACQ_W-1:0]  acq, acq_n;
   logic [RUN_W-1:0]  run, run_n;
   logic [WIN_W-1:0]  win, win_n;
   logic              seen, seen_n;
   logic              idle_hit;

   assign idle_hit = desc_bit && (run >= RUN_HIT);

   always_comb begin
      st_n   = st;
      fill_n = fill;
      acq_n  = acq;
      run_n  = run;
      win_n  = win;
      seen_n = seen;
      if (hold) begin
         st_n   = SYNC_HUNT;
         fill_n = '0;
         acq_n  = '0;
      end else if (bit_vld) begin
         unique case (st)
            SYNC_HUNT: begin
               if (fill != FILL_MAX) begin
                  fill_n = fill + 1'b1;
               end else if (!desc_bit) begin
                  acq_n = '0;
               end else if (acq == ACQ_LAST) begin
                  if (hist_nz) begin
                     st_n   = SYNC_LOCK;
                     acq_n  = '0;
                     run_n  = '0;
                     win_n  = '0;
                     seen_n = 1'b0;
                  end
               end else begin
                  acq_n = acq + 1'b1;
               end
            end
            SYNC_LOCK: begin
               if (!desc_bit)           run_n = '0;
               else if (run != RUN_MAX) run_n = run + 1'b1;
               if (win == WIN_LAST) begin
                  if (seen || idle_hit) begin
                     win_n  = '0;
                     seen_n = 1'b0;
                  end else begin
                     st_n   = SYNC_HUNT;
                     fill_n = '0;
                     acq_n  = '0;
                  end
               end else begin
                  win_n = win + 1'b1;
                  if (idle_hit) seen_n = 1'b1;
               end
            end
            default: st_n = SYNC_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SYNC_HUNT;
         fill <= '0;
         acq  <= '0;
         run  <= '0;
         win  <= '0;
         seen <= 1'b0;
      end else begin
         st   <= st_n;
         fill <= fill_n;
         acq  <= acq_n;
         run  <= run_n;
         win  <= win_n;
         seen <= seen_n;
      end
   end

   assign locked   = (st == SYNC_LOCK);
   assign lock_nxt = (st_n == SYNC_LOCK);
   assign hunting  = (st == SYNC_HUNT);

endmodule

// File: rtl/dsc_grouper.sv
module dsc_grouper #(
   parameter int             GRP_W = 5,
   parameter logic [2*GRP_W-1:0] DELIM = '0,
   parameter logic [GRP_W-1:0]   IDLE  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             d_bit,
   input  logic             det_en,
   input  logic             clr,
   output logic [GRP_W-1:0] grp_data,
   output logic             grp_vld,
   output logic             aligned
);

   localparam int SR_W = 2 * GRP_W;
   localparam int PH_W = $clog2(GRP_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

   logic [SR_W-1:0] sr, sr_n;
   logic [PH_W-1:0] phase, ph_n;
   logic            al_n, emit;

   assign sr_n = bit_vld ? {sr[SR_W-2:0], d_bit} : sr;

   always_comb begin
      al_n = aligned;
      ph_n = phase;
      emit = 1'b0;
      if (clr) begin
         al_n = 1'b0;
      end else if (bit_vld) begin
         if (!aligned) begin
            if (det_en && (sr_n == DELIM)) begin
               al_n = 1'b1;
               emit = 1'b1;
               ph_n = '0;
            end
         end else if (phase == PH_LAST) begin
            emit = 1'b1;
            ph_n = '0;
         end else begin
            ph_n = phase + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr       <= '0;
         phase    <= '0;
         aligned  <= 1'b0;
         grp_vld  <= 1'b0;
         grp_data <= IDLE;
      end else begin
         sr      <= sr_n;
         phase   <= ph_n;
         aligned <= al_n;
         grp_vld <= emit;
         if (emit)       grp_data <= sr_n[SR_W-1:GRP_W];
         else if (!al_n) grp_data <= IDLE;
      end
   end

endmodule

// File: rtl/idle_sync_descrambler.sv
module idle_sync_descrambler #(
   parameter int LFSR_LEN = 11,
   parameter int LFSR_TAP = 9,
   parameter int ACQ_RUN  = 30,
   parameter int IDLE_RUN = 25,
   parameter int WIN_LEN  = 125000,
   parameter int GRP_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             rx_vld,
   input  logic             bypass,
   input  logic             mode_10m,
   output logic [GRP_W-1:0] grp_data,
   output logic             grp_vld,
   output logic             locked,
   output logic             aligned
);

   localparam logic [2*GRP_W-1:0] DELIM = (2*GRP_W)'(dsc_pkg::SSD_PAIR);
   localparam logic [GRP_W-1:0]   IDLE  = GRP_W'(dsc_pkg::IDLE_CODE);

   if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_LEN) begin : g_bad_tap
      $error("LFSR_TAP must lie inside the key register");
   end
   if (ACQ_RUN < 2) begin : g_bad_acq
      $error("ACQ_RUN must be at least 2");
   end
   if (IDLE_RUN < 2 || WIN_LEN <= IDLE_RUN) begin : g_bad_win
      $error("WIN_LEN must exceed IDLE_RUN, IDLE_RUN at least 2");
   end
   if (GRP_W != 5) begin : g_bad_grp
      $error("delimiter pair is defined for 5-bit code groups");
   end

   logic pass_sel, pass_q, ctl_chg;
   logic ks_bit, hist_nz, hunting, lock_nxt;
   logic desc_bit, d_bit, det_en, grp_clr;

   assign pass_sel = bypass | mode_10m;
   assign ctl_chg  = pass_sel ^ pass_q;
   assign desc_bit = rx_bit ^ ks_bit;
   assign d_bit    = pass_sel ? rx_bit : desc_bit;
   assign det_en   = pass_sel | (locked & lock_nxt);
   assign grp_clr  = ctl_chg | (~pass_sel & ~lock_nxt);

   always_ff @(posedge clk) begin
      if (!rst_n) pass_q <= 1'b0;
      else        pass_q <= pass_sel;
   end

   dsc_keystream #(
      .LEN (LFSR_LEN),
      .TAP (LFSR_TAP)
   ) u_ks (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rx_vld),
      .load_raw (hunting),
      .rx_bit   (rx_bit),
      .ks_bit   (ks_bit),
      .hist_nz  (hist_nz)
   );

   dsc_sync_mon #(
      .LEN      (LFSR_LEN),
      .ACQ_RUN  (ACQ_RUN),
      .IDLE_RUN (IDLE_RUN),
      .WIN_LEN  (WIN_LEN)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (pass_sel),
      .bit_vld  (rx_vld),
      .desc_bit (desc_bit),
      .hist_nz  (hist_nz),
      .locked   (locked),
      .lock_nxt (lock_nxt),
      .hunting  (hunting)
   );

   dsc_grouper #(
      .GRP_W (GRP_W),
      .DELIM (DELIM),
      .IDLE  (IDLE)
   ) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (rx_vld),
      .d_bit    (d_bit),
      .det_en   (det_en),
      .clr      (grp_clr),
      .grp_data (grp_data),
      .grp_vld  (grp_vld),
      .aligned  (aligned)
   );

endmodule

// File: rtl/idle_sync_descrambler_chk.sv
module idle_sync_descrambler_chk #(
   parameter int GRP_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_vld,
   input logic             bypass,
   input logic             mode_10m,
   input logic [GRP_W-1:0] grp_data,
   input logic             grp_vld,
   input logic             locked,
   input logic             aligned
);

   AST_STRB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      grp_vld |-> aligned);                                          // R7
   AST_IDLE_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |-> (grp_data == {GRP_W{1'b1}}));                     // R7
   AST_STRB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      grp_vld |=> !grp_vld);                                         // R6
   AST_ALIGN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !mode_10m) |=> (!aligned || locked));              // R8
   AST_PASS_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass || mode_10m) |=> !locked);                             // R9
   AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(rx_vld));                              // R12

endmodule

bind idle_sync_descrambler idle_sync_descrambler_chk #(.GRP_W(GRP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_vld   (rx_vld),
   .bypass   (bypass),
   .mode_10m (mode_10m),
   .grp_data (grp_data),
   .grp_vld  (grp_vld),
   .locked   (locked),
   .aligned  (aligned)
);

// File: tb/idle_sync_descrambler_bench.sv
module idle_sync_descrambler_bench;

   localparam int WIN = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_vld = 1'b0;
   logic       bypass = 1'b0;
   logic       mode_10m = 1'b0;
   logic [4:0] grp_data;
   logic       grp_vld;
   logic       locked;
   logic       aligned;

   int n_chk = 0;
   int n_fail = 0;
   int win_k = 0;
   bit done = 0;
   logic [10:0] tx_s = 11'h5A3;
   logic [4:0]  exp_q[$];

   always #4 clk = ~clk;

   idle_sync_descrambler #(.WIN_LEN(WIN)) u_idle_sync_descrambler (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
      .bypass(bypass), .mode_10m(mode_10m), .grp_data(grp_data),
      .grp_vld(grp_vld), .locked(locked), .aligned(aligned));

   task automatic chk(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // one valid bit; scrambled with s[n] = s[n-11] ^ s[n-9] when scr is set
   task automatic send_bit(input logic b, input logic scr);
      logic s;
      @(negedge clk);
      if (scr) begin
         s = tx_s[10] ^ tx_s[8];
         tx_s = {tx_s[9:0], s};
         rx_bit = b ^ s;
      end else begin
         rx_bit = b;
      end
      rx_vld = 1'b1;
      @(posedge clk);
      #1 rx_vld = 1'b0;
      win_k++;
   endtask

   task automatic send_grp(input logic [4:0] g, input logic scr, input bit expect_it);
      if (expect_it) exp_q.push_back(g);
      for (int i = 4; i >= 0; i--) send_bit(g[i], scr);
   endtask

   task automatic send_run(input int n, input logic b);
      for (int i = 0; i < n; i++) send_bit(b, 1'b1);
   endtask

   // monitor: compares presented groups against the scoreboard queue (R3, R6)
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (grp_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R6: actual group %b expected none", grp_data);
            end else begin
               logic [4:0] e;
               e = exp_q.pop_front();
               if (grp_data !== e) begin
                  n_fail++;
                  $display("FAIL R3/R6: actual group %b expected %b", grp_data, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [4:0] frame [8];
      frame = '{5'b01110, 5'b10100, 5'b01010, 5'b11110,
                5'b10010, 5'b01011, 5'b10101, 5'b11010};

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(locked, 0, "R1");
      chk(aligned, 0, "R1");
      chk(grp_vld, 0, "R1");
      chk(grp_data, 5'b11111, "R1");

      // R2 acquisition from idle: 11 seed bits + 30 matches
      send_run(40, 1'b1);
      chk(locked, 0, "R2");
      send_run(1, 1'b1);
      chk(locked, 1, "R2");
      win_k = 0;

      // window 1: idle only; R7 no groups while unaligned
      send_run(WIN, 1'b1);
      chk(aligned, 0, "R7");
      chk(grp_data, 5'b11111, "R7");
      // window 2: a single run of exactly 25 ones keeps lock (R4)
      send_run(100, 1'b0);
      send_run(25, 1'b1);
      send_run(WIN - 125, 1'b0);
      chk(locked, 1, "R4");
      // window 3: longest run is 24, lock drops on the last bit (R5)
      send_run(100, 1'b0);
      send_run(24, 1'b1);
      send_run(WIN - 125, 1'b0);
      chk(locked, 1, "R4");
      send_run(1, 1'b0);
      chk(locked, 0, "R5");

      // R5 reacquisition again needs 11 + 30 bits
      send_run(40, 1'b1);
      chk(locked, 0, "R5");
      send_run(1, 1'b1);
      chk(locked, 1, "R5");
      win_k = 0;

      // frame: idle, delimiter, data with gaps (R3, R6, R12)
      for (int i = 0; i < 4; i++) send_grp(5'b11111, 1'b1, 0);
      chk(aligned, 0, "R8");
      send_grp(5'b11000, 1'b1, 1);
      send_grp(5'b10001, 1'b1, 1);
      chk(aligned, 1, "R6");
      for (int i = 0; i < 8; i++) begin
         send_grp(frame[i], 1'b1, 1);
         if (i == 2) repeat (3) @(posedge clk);   // R12 gap without valid
      end
      while (win_k < WIN) send_grp(5'b11111, 1'b1, 1);
      chk(locked, 1, "R4");

      // R8: a window of zero groups; the last two groups are never presented
      for (int i = 0; i < WIN / 5; i++) send_grp(5'b00000, 1'b1, i < WIN / 5 - 2);
      chk(locked, 0, "R5");
      chk(aligned, 0, "R8");
      chk(grp_data, 5'b11111, "R8");

      // R9 bypass: raw bits, no lock
      @(negedge clk) bypass = 1'b1;
      @(posedge clk); #1;
      chk(locked, 0, "R9");
      send_grp(5'b11111, 1'b0, 0);
      send_grp(5'b11111, 1'b0, 0);
      send_grp(5'b11000, 1'b0, 1);
      send_grp(5'b10001, 1'b0, 1);
      for (int i = 0; i < 4; i++) send_grp(frame[i], 1'b0, 1);
      chk(aligned, 1, "R9");
      send_grp(5'b11111, 1'b0, 0);
      chk(locked, 0, "R9");

      // R11 leaving pass-through clears alignment
      @(negedge clk) bypass = 1'b0;
      @(posedge clk); #1;
      chk(aligned, 0, "R11");

      // R10 10 Mb/s pass-through
      @(negedge clk) mode_10m = 1'b1;
      @(posedge clk); #1;
      chk(aligned, 0, "R11");
      send_grp(5'b11111, 1'b0, 0);
      send_grp(5'b11000, 1'b0, 1);
      send_grp(5'b10001, 1'b0, 1);
      for (int i = 4; i < 8; i++) send_grp(frame[i], 1'b0, 1);
      send_grp(5'b11111, 1'b0, 0);
      chk(aligned, 1, "R10");
      chk(locked, 0, "R10");

      repeat (4) @(posedge clk);
      #3;
      chk(exp_q.size(), 0, "R6");
      report();
   end

endmodule